// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit resolves the operand of an instruction that has already been decoded. It takes a three-bit addressing-mode code, an address/displacement field, one register specifier and the current program counter. From these it forms the effective address and fetches the operand. It reads the register file through a combinational read port. Memory is reached through a single read channel: a one-cycle request carries the address, and the unit then waits for a valid strobe that carries the data.

Depending on the mode, the unit issues no memory read, one read, or two dependent reads. In the two-read case, the first read returns a pointer and the second read fetches the operand at that pointer. When the operand is ready, the unit raises a one-cycle completion pulse. The effective address and operand outputs then stay unchanged until the next accepted start.

The control machine has five states:
- IDLE: waits for start and latches the instruction fields.
- CALC: reads the register and forms the address.
- REQ: issues one read request.
- WAIT: holds until the read data is valid.
- DONE: emits the completion pulse.

The transitions are:
- IDLE→CALC when start is high.
- CALC→DONE for modes that need no memory.
- CALC→REQ for all other modes.
- REQ→WAIT unconditionally.
- WAIT→REQ on valid data while a pointer hop is still pending.
- WAIT→DONE on valid data for the final read.
- DONE→IDLE unconditionally.

Top module: `ea_unit`

## Requirements
- R1: Mode code 0 (immediate): operand equals the field zero-extended, the effective address output is 0, and no memory read is issued.
- R2: Mode code 1 (register): operand equals the content of the named register, the effective address output is 0, and no memory read is issued.
- R3: Mode code 2 (direct): exactly one read is issued, at the field value. The effective address equals the field, and the operand is the returned data.
- R4: Mode code 3 (indirect): exactly two reads are issued in order. The first is at the field. The second is at the pointer returned by the first, taken from the low address-width bits of the data. The effective address is that pointer, and the operand is the second read's data.
- R5: Mode code 4 (register indirect): exactly one read is issued, at the named register's content. That content is the effective address.
- R6: Mode codes 5 (indexed) and 6 (base plus displacement): exactly one read is issued, at field plus the named register's content, modulo 2^AW. That sum is the effective address.
- R7: Mode code 7 (PC-relative): exactly one read is issued, at program counter plus field, modulo 2^AW. That sum is the effective address.
- R8: Every read request lasts exactly one cycle. The unit waits any number of cycles for the valid strobe and issues no request while it waits.
- R9: done is high for exactly one cycle per accepted start. The effective address and operand stay stable from then until the next start.
- R10: A start that arrives while an operation is in progress has no effect: no extra completion, no extra read, and no change to the result.
- R11: After reset, done and mem_req are low, and the effective address and operand outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving the presented fields |
| mode | input | 3 | Addressing-mode code |
| field | input | AW | Address, displacement or immediate field |
| reg_sel | input | RSW | Register specifier (index, base or pointer register) |
| pc | input | AW | Current program counter |
| rf_addr | output | RSW | Register-file read address |
| rf_data | input | DW | Register-file read data (combinational) |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | AW | Read address |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | DW | Read data |
| done | output | 1 | Operand ready pulse |
| ea | output | AW | Effective address |
| operand | output | DW | Resolved operand |

## Verification
A corrupted state register would show up at the ports within a few cycles. It would appear as a missing or doubled done pulse, or a read request with no completion. It could also appear as a request repeated while waiting.

A wrong pointer-hop flag would show up at the memory interface immediately. It would produce a second read in a single-read mode, or a missing second read in indirect mode.

Address arithmetic faults would appear on the first read address. They would be confirmed again on the effective address output at completion, so the bench compares both the logged read addresses and the final outputs for every mode, including wrapping sums.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [2:0] {
        M_IMM   = 3'd0,
        M_REG   = 3'd1,
        M_DIR   = 3'd2,
        M_IND   = 3'd3,
        M_RIND  = 3'd4,
        M_IDX   = 3'd5,
        M_BASE  = 3'd6,
        M_REL   = 3'd7
    } mode_t;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_CALC = 3'd1,
        S_REQ  = 3'd2,
        S_WAIT = 3'd3,
        S_DONE = 3'd4
    } state_t;

endpackage

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  mode_t         mode_i,
    input  logic [AW-1:0] field_i,
    input  logic [DW-1:0] reg_i,
    input  logic [AW-1:0] pc_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] imm_o,
    output logic          no_mem_o,
    output logic          hop_o
);
    logic [AW-1:0] reg_addr;

    assign reg_addr = reg_i[AW-1:0];

    generate
        if (DW > AW) begin : g_wide
            assign imm_o = {{(DW-AW){1'b0}}, field_i};
        end else begin : g_same
            assign imm_o = field_i;
        end
    endgenerate

    always_comb begin
        addr_o   = field_i;
        no_mem_o = 1'b0;
        hop_o    = 1'b0;
        unique case (mode_i)
            M_IMM:  no_mem_o = 1'b1;
            M_REG:  no_mem_o = 1'b1;
            M_DIR:  addr_o   = field_i;
            M_IND:  hop_o    = 1'b1;
            M_RIND: addr_o   = reg_addr;
            M_IDX:  addr_o   = field_i + reg_addr;
            M_BASE: addr_o   = reg_addr + field_i;
            M_REL:  addr_o   = pc_i + field_i;
        endcase
    end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import ea_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int RSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     mode,
    input  logic [AW-1:0]  field,
    input  logic [RSW-1:0] reg_sel,
    input  logic [AW-1:0]  pc,
    input  logic [DW-1:0]  rf_data,
    input  logic [AW-1:0]  calc_addr,
    input  logic [DW-1:0]  calc_imm,
    input  logic           calc_no_mem,
    input  logic           calc_hop,
    input  logic           mem_valid,
    input  logic [DW-1:0]  mem_data,
    output mode_t          mode_q,
    output logic [AW-1:0]  field_q,
    output logic [AW-1:0]  pc_q,
    output logic [RSW-1:0] rf_addr,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    output logic           done,
    output logic [AW-1:0]  ea,
    output logic [DW-1:0]  operand
);
    state_t         state, nxt;
    logic [RSW-1:0] reg_q;
    logic [AW-1:0]  addr_q;
    logic           hop_q;
    logic [AW-1:0]  ea_q;
    logic [DW-1:0]  opnd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start) nxt = S_CALC;
            S_CALC: nxt = calc_no_mem ? S_DONE : S_REQ;
            S_REQ:  nxt = S_WAIT;
            S_WAIT: if (mem_valid) nxt = hop_q ? S_REQ : S_DONE;
            S_DONE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= M_IMM;
            field_q <= '0;
            pc_q    <= '0;
            reg_q   <= '0;
            addr_q  <= '0;
            hop_q   <= 1'b0;
            ea_q    <= '0;
            opnd_q  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    mode_q  <= mode_t'(mode);
                    field_q <= field;
                    pc_q    <= pc;
                    reg_q   <= reg_sel;
                end
                S_CALC: begin
                    addr_q <= calc_addr;
                    hop_q  <= calc_hop;
                    if (mode_q == M_IMM) begin
                        opnd_q <= calc_imm;
                        ea_q   <= '0;
                    end else if (mode_q == M_REG) begin
                        opnd_q <= rf_data;
                        ea_q   <= '0;
                    end
                end
                S_WAIT: if (mem_valid) begin
                    if (hop_q) begin
                        addr_q <= mem_data[AW-1:0];
                        hop_q  <= 1'b0;
                    end else begin
                        ea_q   <= addr_q;
                        opnd_q <= mem_data;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rf_addr  = reg_q;
        mem_req  = (state == S_REQ);
        mem_addr = addr_q;
        done     = (state == S_DONE);
        ea       = ea_q;
        operand  = opnd_q;
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    assert_no_req_waiting_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT) |-> !mem_req);
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start) |=> ($stable(ea) && $stable(operand)));
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> (state != S_CALC));
    assert_no_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CALC && (mode_q == M_IMM || mode_q == M_REG)) |=> !mem_req);
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int RSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     mode,
    input  logic [AW-1:0]  field,
    input  logic [RSW-1:0] reg_sel,
    input  logic [AW-1:0]  pc,
    output logic [RSW-1:0] rf_addr,
    input  logic [DW-1:0]  rf_data,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    input  logic           mem_valid,
    input  logic [DW-1:0]  mem_data,
    output logic           done,
    output logic [AW-1:0]  ea,
    output logic [DW-1:0]  operand
);
    localparam bit WIDTH_OK = (DW >= AW);

    mode_t         mode_q;
    logic [AW-1:0] field_q;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] calc_addr;
    logic [DW-1:0] calc_imm;
    logic          calc_no_mem;
    logic          calc_hop;

    initial assert (WIDTH_OK) else $error("data width must cover the address width");

    ea_addr_calc #(.AW(AW), .DW(DW)) u_calc (
        .mode_i   (mode_q),
        .field_i  (field_q),
        .reg_i    (rf_data),
        .pc_i     (pc_q),
        .addr_o   (calc_addr),
        .imm_o    (calc_imm),
        .no_mem_o (calc_no_mem),
        .hop_o    (calc_hop)
    );

    ea_ctrl #(.AW(AW), .DW(DW), .RSW(RSW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode        (mode),
        .field       (field),
        .reg_sel     (reg_sel),
        .pc          (pc),
        .rf_data     (rf_data),
        .calc_addr   (calc_addr),
        .calc_imm    (calc_imm),
        .calc_no_mem (calc_no_mem),
        .calc_hop    (calc_hop),
        .mem_valid   (mem_valid),
        .mem_data    (mem_data),
        .mode_q      (mode_q),
        .field_q     (field_q),
        .pc_q        (pc_q),
        .rf_addr     (rf_addr),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .done        (done),
        .ea          (ea),
        .operand     (operand)
    );
endmodule

// File: tb/ea_unit_test.sv
module ea_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    localparam logic [2:0]  V_MODE [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7, 3'd7, 3'd5};
    localparam logic [15:0] V_FLD  [NV] = '{16'h1234, 16'h0000, 16'h0400, 16'h0800, 16'h0000,
                                           16'h07D0, 16'h00FA, 16'h0020, 16'h0020, 16'hFF00};
    localparam logic [3:0]  V_REG  [NV] = '{4'd3, 4'd5, 4'd0, 4'd0, 4'd2, 4'd1, 4'd7, 4'd0, 4'd0, 4'd15};
    localparam logic [15:0] V_PC   [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
                                           16'h0000, 16'h0000, 16'h1000, 16'hFFF0, 16'h0000};
    localparam int          V_RDS  [NV] = '{0, 0, 1, 2, 1, 1, 1, 1, 1, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [15:0] field = '0;
    logic [3:0]  reg_sel = '0;
    logic [15:0] pc = '0;
    logic [3:0]  rf_addr;
    logic [15:0] rf_data;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [15:0] mem_data = '0;
    logic        done;
    logic [15:0] ea;
    logic [15:0] operand;

    int errors = 0;
    int checks = 0;
    int lat = 0;
    int reads_seen = 0;
    logic [15:0] rd_log [256];
    logic        pend = 1'b0;
    logic [15:0] paddr = '0;
    int          wcnt = 0;
    int          cyc = 0;

    function automatic logic [15:0] rf_val(input logic [3:0] r);
        return 16'h0F00 + 16'(r) * 16'd100;
    endfunction

    function automatic logic [15:0] mem_val(input logic [15:0] a);
        return a ^ 16'h3C5A;
    endfunction

    assign rf_data = rf_val(rf_addr);

    ea_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
        .reg_sel(reg_sel), .pc(pc), .rf_addr(rf_addr), .rf_data(rf_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_data(mem_data), .done(done), .ea(ea), .operand(operand)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_valid <= 1'b0;
        if (mem_req) begin
            pend <= 1'b1;
            paddr <= mem_addr;
            wcnt <= lat;
            rd_log[reads_seen[7:0]] <= mem_addr;
            reads_seen <= reads_seen + 1;
        end else if (pend) begin
            if (wcnt == 0) begin
                mem_valid <= 1'b1;
                mem_data  <= mem_val(paddr);
                pend      <= 1'b0;
            end else begin
                wcnt <= wcnt - 1;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] m, input logic [15:0] f,
                         input logic [3:0] r, input logic [15:0] p);
        @(negedge clk);
        mode = m; field = f; reg_sel = r; pc = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req, output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        if (!ok) check(req, "done timeout", 32'd0, 32'd1);
    endtask

    initial begin
        logic [15:0] exp_ea, exp_op, ptr;
        int base, n;
        bit ok;
        repeat (3) @(negedge clk);
        // R11: reset values
        check("R11", "done", {31'd0, done}, 32'd0);
        check("R11", "mem_req", {31'd0, mem_req}, 32'd0);
        check("R11", "ea", {16'd0, ea}, 32'd0);
        check("R11", "operand", {16'd0, operand}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            lat = i % 3;
            base = reads_seen;
            ptr = mem_val(V_FLD[i]);
            case (V_MODE[i])
                3'd0: begin exp_ea = 16'h0; exp_op = V_FLD[i]; end
                3'd1: begin exp_ea = 16'h0; exp_op = rf_val(V_REG[i]); end
                3'd2: begin exp_ea = V_FLD[i]; exp_op = mem_val(exp_ea); end
                3'd3: begin exp_ea = ptr; exp_op = mem_val(ptr); end
                3'd4: begin exp_ea = rf_val(V_REG[i]); exp_op = mem_val(exp_ea); end
                3'd7: begin exp_ea = V_PC[i] + V_FLD[i]; exp_op = mem_val(exp_ea); end
                default: begin exp_ea = V_FLD[i] + rf_val(V_REG[i]); exp_op = mem_val(exp_ea); end
            endcase
            issue(V_MODE[i], V_FLD[i], V_REG[i], V_PC[i]);
            wait_done("R9", ok);
            // R1 R2 R3 R4 R5 R6 R7: per-mode results
            check("R1-7 mode", "ea", {16'd0, ea}, {16'd0, exp_ea});
            check("R1-7 mode", "operand", {16'd0, operand}, {16'd0, exp_op});
            n = reads_seen - base;
            check("R8 reads", "count", n, V_RDS[i]);
            if (V_MODE[i] == 3'd3 && n == 2) begin
                check("R4", "first addr", {16'd0, rd_log[base[7:0]]}, {16'd0, V_FLD[i]});
                check("R4", "second addr", {16'd0, rd_log[8'(base + 1)]}, {16'd0, ptr});
            end else if (n == 1) begin
                check("R3", "read addr", {16'd0, rd_log[base[7:0]]}, {16'd0, exp_ea});
            end
            @(negedge clk);
            check("R9", "done one cycle", {31'd0, done}, 32'd0);
            repeat (2) @(negedge clk);
            check("R9", "ea held", {16'd0, ea}, {16'd0, exp_ea});
        end

        // R10: start during a slow read is ignored
        lat = 6;
        base = reads_seen;
        issue(3'd2, 16'h0100, 4'd0, 16'h0);
        repeat (2) @(negedge clk);
        issue(3'd0, 16'h0AAA, 4'd0, 16'h0);
        wait_done("R10", ok);
        check("R10", "ea", {16'd0, ea}, 32'h0100);
        check("R10", "operand", {16'd0, operand}, {16'd0, mem_val(16'h0100)});
        n = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (done) n++;
        end
        check("R10", "extra done", n, 0);
        check("R10", "reads", reads_seen - base, 1);
        check("R10", "ea unchanged", {16'd0, ea}, 32'h0100);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule